// File: doc/BRIEF.md
# Sliced Four-Operation ALU

This block is a purely combinational arithmetic/logic unit. It is built from identical one-bit slices, and groups of four slices form a nibble unit. Its default width is 16 bits. A two-bit operation select picks bitwise AND, bitwise OR, bitwise XOR, or binary addition with carry-in. It returns the result word and one carry-out bit.

Each slice takes an operand bit from each word, an incoming carry and the decoded operation. It produces one result bit and an outgoing carry. Slices chain on their carries inside a nibble, and nibbles chain the same way across the word. The carry chain is live only during addition. For the three logic operations every slice drives its carry low, so the carry-in has no effect and the carry-out reads zero. The width is set by the number of nibbles.

Top module: `alu_sliced`

## Requirements
- R1: The select encoding is 2'b00 for AND, 2'b01 for OR, 2'b10 for XOR and 2'b11 for ADD, and the logic operations act bit by bit on the two operands.
- R2: With select 2'b11, {carryOut, result} equals opA + opB + carryIn over the full width, taken as unsigned values.
- R3: With any logic select (2'b00, 2'b01, 2'b10), carryOut is 0 and no nibble passes a carry to the next one.
- R4: With any logic select, toggling carryIn leaves result unchanged.
- R5: A carry out of one nibble enters the next. 0x000C + 0x0009 with carryIn 0 gives 0x0015 with carryOut 0. 0xC000 + 0x9000 gives 0x5000 with carryOut 1.
- R6: With opA=0x000C, opB=0x0009 and carryIn 0, AND gives 0x0008, OR gives 0x000D and XOR gives 0x0005, each with carryOut 0. 0x0002 + 0x0004 gives 0x0006 with carryOut 0.
- R7: A carry ripples through every slice. 0xFFFF + 0x0000 with carryIn 1 gives 0x0000 with carryOut 1.
- R8: The block holds no state. result and carryOut follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4*NUM_NIBBLES | First operand |
| opB | input | 4*NUM_NIBBLES | Second operand |
| carryIn | input | 1 | Carry into the lowest slice, used only by ADD |
| opSel | input | 2 | Operation select (see R1) |
| result | output | 4*NUM_NIBBLES | Operation result |
| carryOut | output | 1 | Carry out of the top slice, zero for logic operations |

## Verification
On every input change, the assertions check the following:
- the carry-out and every inter-nibble carry are zero for the logic selects;
- each logic result is consistent bit by bit with its operands;
- an addition matches the wide sum of the operands and the carry-in.

Some behaviours can only be shown by the bench's scenarios. One is that the carry-in has no effect in logic modes, which needs the same operands applied with both carry-in values. The worked examples, the full-length ripple, and the output settling without a clock edge are also shown by the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_XOR = 2'b10,
    OP_ADD = 2'b11
  } aluOp_e;

  // One-hot strobes from the decoder to every slice
  typedef struct packed {
    logic selAnd;
    logic selOr;
    logic selXor;
    logic selAdd;
  } sliceCtrl_t;

  localparam int SLICES_PER_NIBBLE = 4;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0] opSel,
  output sliceCtrl_t ctrl
);

  always_comb begin
    ctrl = '0;
    case (aluOp_e'(opSel))
      OP_AND:  ctrl.selAnd = 1'b1;
      OP_OR:   ctrl.selOr  = 1'b1;
      OP_XOR:  ctrl.selXor = 1'b1;
      default: ctrl.selAdd = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       cin,
  input  sliceCtrl_t ctrl,
  output logic       f,
  output logic       cout
);

  logic andBit;
  logic orBit;
  logic xorBit;
  logic sumBit;

  always_comb begin
    andBit = a & b;
    orBit  = a | b;
    xorBit = a ^ b;
    sumBit = xorBit ^ cin;
    f      = (ctrl.selAnd & andBit) | (ctrl.selOr & orBit)
           | (ctrl.selXor & xorBit) | (ctrl.selAdd & sumBit);
    // carry leaves the slice only while adding
    cout   = ctrl.selAdd & (andBit | (cin & xorBit));
  end

endmodule

// File: rtl/alu_nibble.sv
module alu_nibble
  import alu_pkg::*;
(
  input  logic [SLICES_PER_NIBBLE-1:0] a,
  input  logic [SLICES_PER_NIBBLE-1:0] b,
  input  logic                         cin,
  input  sliceCtrl_t                   ctrl,
  output logic [SLICES_PER_NIBBLE-1:0] f,
  output logic                         cout
);

  logic [SLICES_PER_NIBBLE:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < SLICES_PER_NIBBLE; i++) begin : g_slice
    alu_slice u_slice (
      .a    (a[i]),
      .b    (b[i]),
      .cin  (chain[i]),
      .ctrl (ctrl),
      .f    (f[i]),
      .cout (chain[i+1])
    );
  end

  assign cout = chain[SLICES_PER_NIBBLE];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int NUM_NIBBLES = 4,
  localparam int WIDTH = NUM_NIBBLES * SLICES_PER_NIBBLE
) (
  input  logic [WIDTH-1:0]       opA,
  input  logic [WIDTH-1:0]       opB,
  input  logic                   carryIn,
  input  sliceCtrl_t             ctrl,
  output logic [WIDTH-1:0]       result,
  output logic [NUM_NIBBLES-1:0] nibbleCarry
);

  localparam int NW = SLICES_PER_NIBBLE;

  logic [NUM_NIBBLES:0] link;

  assign link[0] = carryIn;

  for (genvar n = 0; n < NUM_NIBBLES; n++) begin : g_nibble
    alu_nibble u_nibble (
      .a    (opA[n*NW +: NW]),
      .b    (opB[n*NW +: NW]),
      .cin  (link[n]),
      .ctrl (ctrl),
      .f    (result[n*NW +: NW]),
      .cout (link[n+1])
    );
    assign nibbleCarry[n] = link[n+1];
  end

endmodule

// File: rtl/alu_sliced.sv
module alu_sliced
  import alu_pkg::*;
#(
  parameter int NUM_NIBBLES = 4,
  localparam int WIDTH = NUM_NIBBLES * SLICES_PER_NIBBLE
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [1:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  sliceCtrl_t             ctrl;
  logic [NUM_NIBBLES-1:0] nibbleCarry;

  alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu_datapath #(.NUM_NIBBLES(NUM_NIBBLES)) u_dp (
    .opA         (opA),
    .opB         (opB),
    .carryIn     (carryIn),
    .ctrl        (ctrl),
    .result      (result),
    .nibbleCarry (nibbleCarry)
  );

  assign carryOut = nibbleCarry[NUM_NIBBLES-1];

endmodule

// File: rtl/alu_sliced_chk.sv
module alu_sliced_chk #(
  parameter int NUM_NIBBLES = 4,
  localparam int WIDTH = NUM_NIBBLES * 4
) (
  input logic [WIDTH-1:0]       opA,
  input logic [WIDTH-1:0]       opB,
  input logic                   carryIn,
  input logic [1:0]             opSel,
  input logic [WIDTH-1:0]       result,
  input logic                   carryOut,
  input logic [NUM_NIBBLES-1:0] nibbleCarry
);

  logic [WIDTH:0] wideSum;

  always_comb begin
    wideSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

    // R3
    logic_carry_low_chk: assert (opSel == 2'b11 || (carryOut == 1'b0 && nibbleCarry == '0));

    // R1
    and_subset_chk: assert (opSel != 2'b00 || (result & ~(opA & opB)) == '0);

    // R1
    or_cover_chk: assert (opSel != 2'b01 || ((result & (opA | opB)) == (opA | opB) && (result & ~(opA | opB)) == '0));

    // R1
    xor_inverse_chk: assert (opSel != 2'b10 || (result ^ opA) == opB);

    // R2
    add_sum_chk: assert (opSel != 2'b11 || {carryOut, result} == wideSum);
  end

endmodule

bind alu_sliced alu_sliced_chk #(.NUM_NIBBLES(NUM_NIBBLES)) u_chk (
  .opA         (opA),
  .opB         (opB),
  .carryIn     (carryIn),
  .opSel       (opSel),
  .result      (result),
  .carryOut    (carryOut),
  .nibbleCarry (nibbleCarry)
);

// File: tb/sim_alu_sliced.sv
module sim_alu_sliced;

  localparam int NIB = 4;
  localparam int W = NIB * 4;

  typedef struct {
    logic [W-1:0] expF;
    logic         expC;
    string        tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [1:0]   opSel = 2'b00;
  logic [W-1:0] result;
  logic         carryOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  alu_sliced #(.NUM_NIBBLES(NIB)) u0 (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .opSel    (opSel),
    .result   (result),
    .carryOut (carryOut)
  );

  // reference model taken from R1/R2/R3
  function automatic logic [W:0] refModel(logic [W-1:0] a, logic [W-1:0] b,
                                          logic c, logic [1:0] s);
    case (s)
      2'b00:   return {1'b0, a & b};
      2'b01:   return {1'b0, a | b};
      2'b10:   return {1'b0, a ^ b};
      default: return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    endcase
  endfunction

  task automatic checkOne(string tag, logic [W-1:0] gotF, logic gotC,
                          logic [W-1:0] expF, logic expC);
    testsRun++;
    if (gotF !== expF || gotC !== expC) begin
      testsFailed++;
      $display("FAIL %s: got F=%h C=%b, expected F=%h C=%b", tag, gotF, gotC, expF, expC);
    end
  endtask

  // driver: apply at posedge, queue the expectation
  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic c, logic [1:0] s,
                       logic [W-1:0] expF, logic expC, string tag);
    expItem_t it;
    @(posedge clk);
    opA = a; opB = b; carryIn = c; opSel = s;
    it.expF = expF; it.expC = expC; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic driveRef(logic [W-1:0] a, logic [W-1:0] b, logic c, logic [1:0] s,
                          string tag);
    logic [W:0] r;
    r = refModel(a, b, c, s);
    drive(a, b, c, s, r[W-1:0], r[W], tag);
  endtask

  // monitor: compare at the following negedge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checkOne(it.tag, result, carryOut, it.expF, it.expC);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired: got running, expected finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // reset state: all-zero inputs give zero outputs (R1)
    drive('0, '0, 1'b0, 2'b00, 16'h0000, 1'b0, "R1 idle state");

    // worked examples, R6
    drive(16'h000C, 16'h0009, 1'b0, 2'b00, 16'h0008, 1'b0, "R6 AND example");
    drive(16'h000C, 16'h0009, 1'b0, 2'b01, 16'h000D, 1'b0, "R6 OR example");
    drive(16'h000C, 16'h0009, 1'b0, 2'b10, 16'h0005, 1'b0, "R6 XOR example");
    drive(16'h0002, 16'h0004, 1'b0, 2'b11, 16'h0006, 1'b0, "R6 ADD small");

    // nibble carry hand-off, R5
    drive(16'h000C, 16'h0009, 1'b0, 2'b11, 16'h0015, 1'b0, "R5 low nibble carry");
    drive(16'hC000, 16'h9000, 1'b0, 2'b11, 16'h5000, 1'b1, "R5 top nibble carry");

    // full ripple, R7
    drive(16'hFFFF, 16'h0000, 1'b1, 2'b11, 16'h0000, 1'b1, "R7 full ripple");

    // logic ops ignore carry-in and never carry out, R3 R4
    drive(16'hFFFF, 16'hFFFF, 1'b1, 2'b00, 16'hFFFF, 1'b0, "R3 R4 AND cin1");
    drive(16'hFFFF, 16'h0000, 1'b1, 2'b01, 16'hFFFF, 1'b0, "R3 R4 OR cin1");
    drive(16'hA5A5, 16'h0FF0, 1'b1, 2'b10, 16'hAA55, 1'b0, "R3 R4 XOR cin1");
    drive(16'hA5A5, 16'h0FF0, 1'b0, 2'b10, 16'hAA55, 1'b0, "R3 R4 XOR cin0");

    // random operands, every select, both carry-ins, R1 R2
    for (int i = 0; i < 150; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = W'($urandom);
      rb = W'($urandom);
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 2; c++) begin
          driveRef(ra, rb, c[0], s[1:0], (s == 3) ? "R2 random add" : "R1 random logic");
        end
      end
    end

    // no clock needed: outputs settle mid-cycle, R8
    @(negedge clk);
    #1;
    opA = 16'h1234; opB = 16'h4321; carryIn = 1'b1; opSel = 2'b11;
    #1;
    checkOne("R8 settles without clock", result, carryOut, 16'h5556, 1'b0);

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule